// File: doc/BRIEF.md
# Same-Page Half-Bus Access Pairer

This unit sits in a DRAM memory controller between a small request queue and the column-command issue stage. Each request is a small aligned access with a bank, a row, a column and a direction. The 32-bit data bus is treated as two independent 16-bit halves: bits 15:0 form the lower half and bits 31:16 the upper half. Both halves must address the same open page, which means the same bank and row, but each may use its own column. The unit always serves the oldest request in the lower half. It then looks for the oldest younger request with the same bank, row and direction and places that request in the upper half. The two requests leave as one command.

Three configuration inputs shape each command. The first picks the fast mode (burst of 16) or the slow mode (burst of 8). The second switches on a compatibility mode, in which both halves read the same column and each command carries one request across the full bus. The third decides what happens to a request with no partner. It is either sent as an overfetching full-width access or sent alone on the lower half at half bandwidth. The command also carries a tag for each request it holds, so that returned data can be routed back.

Top module: `halfbus_pairer`

## Requirements
- R1: After reset the queue is empty: `cmd_valid` is 0 and `req_ready` is 1.
- R2: The queue holds 8 requests. `req_ready` is 0 exactly when 8 are held. A request offered while `req_ready` is 0 is dropped and receives no tag.
- R3: Each accepted request receives a tag equal to its acceptance number modulo 16, counting from 0 after reset. While the queue is non-empty, `cmd_valid` is 1 and `cmd_bank`, `cmd_row`, `cmd_write`, `cmd_lo_col` and `cmd_lo_tag` are those of the oldest queued request.
- R4: With `cfg_compat`=0, the partner is the oldest younger request whose bank, row and `write` match the oldest request. When a partner exists, `cmd_hi_valid`=1, `cmd_full`=0, and `cmd_hi_col`/`cmd_hi_tag` are the partner's column and tag.
- R5: A read (`write`=0) and a write (`write`=1) are never placed in the same command, even when they address the same page.
- R6: With `cfg_compat`=1, no pairing takes place: `cmd_hi_valid`=0, `cmd_full`=1, `cmd_hi_col`=`cmd_lo_col` and `cmd_hi_tag`=`cmd_lo_tag`.
- R7: A lone request with `cfg_lone_full`=1 gives `cmd_full`=1, `cmd_hi_valid`=0, `cmd_hi_col`=`cmd_lo_col` and `cmd_hi_tag`=`cmd_lo_tag`.
- R8: A lone request with `cfg_lone_full`=0 gives `cmd_full`=0, `cmd_hi_valid`=0, `cmd_hi_col`=`cmd_lo_col` and `cmd_hi_tag`=`cmd_lo_tag`. Only the lower half moves data.
- R9: `cmd_burst` is 16 when `cfg_qdr`=1 and 8 when `cfg_qdr`=0.
- R10: `cmd_bytes` is 4×burst when both halves move data (a paired or full command) and 2×burst when only one half does. This gives 64/32 bytes at burst 16 and 32/16 bytes at burst 8.
- R11: When a paired command is accepted (`cmd_valid` and `cmd_ready` both 1), both requests leave in that cycle. The remaining requests keep their relative age order.
- R12: While `cmd_ready` is 0, no request leaves the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_qdr | input | 1 | 1: burst 16, 0: burst 8 |
| cfg_compat | input | 1 | 1: both halves share one column, no pairing |
| cfg_lone_full | input | 1 | Lone request: 1 full-width overfetch, 0 lower half only |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_bank | input | 4 | Request bank |
| req_row | input | 14 | Request row |
| req_col | input | 7 | Request column |
| req_write | input | 1 | 1 write, 0 read |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Command taken by the issue stage |
| cmd_bank | output | 4 | Command bank |
| cmd_row | output | 14 | Command row |
| cmd_write | output | 1 | Command direction |
| cmd_lo_col | output | 7 | Lower-half column |
| cmd_lo_tag | output | 4 | Lower-half request tag |
| cmd_hi_valid | output | 1 | Upper half carries a second request |
| cmd_hi_col | output | 7 | Upper-half column |
| cmd_hi_tag | output | 4 | Upper-half request tag |
| cmd_full | output | 1 | Both halves read the lower column |
| cmd_burst | output | 5 | Burst length |
| cmd_bytes | output | 7 | Bytes moved by the command |

## Verification
The bench first offers a directed burst while the issue stage stalls. This fills the queue past its limit, so drops are separated from accepts. The same burst mixes same-page reads and writes with other pages, which shows whether a partner is chosen by bank, row and direction rather than by page alone, and whether the youngest or the oldest candidate wins. Randomised traffic over two banks and two rows then runs under all eight configuration combinations with random back-pressure. This separates the paired, full-width and half-width outcomes and both burst settings. It also tests removal from the middle of the queue, where a wrong shift shows up as a wrong oldest request on a later cycle.

// File: rtl/hbp_pkg.sv
// Shared constants and the command-kind type for the half-bus pairer.
// Assumes a 32-bit bus made of two 16-bit halves (2 bytes per beat per half).
package hbp_pkg;
    localparam int QDR_BURST  = 16;
    localparam int DDR_BURST  = 8;
    localparam int HALF_BYTES = 2;
    localparam int BURST_W    = $clog2(QDR_BURST + 1);
    localparam int BYTES_W    = $clog2(QDR_BURST * 2 * HALF_BYTES + 1);

    typedef enum logic [1:0] {
        KIND_PAIR = 2'd0,
        KIND_HALF = 2'd1,
        KIND_FULL = 2'd2
    } hbp_kind_e;
endpackage

// File: rtl/hbp_queue.sv
// Age-ordered request store. Slot 0 always holds the oldest request.
// Assumes a pop always removes slot 0 and, when pop_two is set, also slot
// pop_idx (>0). Assumes push is only asserted while count < DEPTH.
// Survivors shift down and keep their order; a push lands after them.
module hbp_queue #(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 4,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 7,
    parameter int TAG_W  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BANK_W-1:0] push_bank,
    input  logic [ROW_W-1:0]  push_row,
    input  logic [COL_W-1:0]  push_col,
    input  logic              push_write,
    input  logic              pop,
    input  logic              pop_two,
    input  logic [IDX_W-1:0]  pop_idx,
    output logic [CNT_W-1:0]  count,
    output logic [BANK_W-1:0] q_bank  [DEPTH],
    output logic [ROW_W-1:0]  q_row   [DEPTH],
    output logic [COL_W-1:0]  q_col   [DEPTH],
    output logic              q_write [DEPTH],
    output logic [TAG_W-1:0]  q_tag   [DEPTH]
);
    logic [BANK_W-1:0] n_bank  [DEPTH];
    logic [ROW_W-1:0]  n_row   [DEPTH];
    logic [COL_W-1:0]  n_col   [DEPTH];
    logic              n_write [DEPTH];
    logic [TAG_W-1:0]  n_tag   [DEPTH];
    logic [CNT_W-1:0]  cnt_left;
    logic [TAG_W-1:0]  seq;

    // Next contents: shift out removed slots, then append the new request.
    always_comb begin
        n_bank  = q_bank;
        n_row   = q_row;
        n_col   = q_col;
        n_write = q_write;
        n_tag   = q_tag;
        for (int k = 0; k < DEPTH; k++) begin
            int src;
            src = k + (pop ? ((pop_two && (k + 1 >= int'(pop_idx))) ? 2 : 1) : 0);
            if (src < DEPTH) begin
                n_bank[k]  = q_bank[src];
                n_row[k]   = q_row[src];
                n_col[k]   = q_col[src];
                n_write[k] = q_write[src];
                n_tag[k]   = q_tag[src];
            end
        end
        cnt_left = count - CNT_W'(pop ? (pop_two ? 2 : 1) : 0);
        if (push) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (k == int'(cnt_left)) begin
                    n_bank[k]  = push_bank;
                    n_row[k]   = push_row;
                    n_col[k]   = push_col;
                    n_write[k] = push_write;
                    n_tag[k]   = seq;
                end
            end
        end
    end

    // Occupancy and tag sequence, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            seq   <= '0;
        end else begin
            count <= cnt_left + CNT_W'(push);
            seq   <= seq + TAG_W'(push);
        end
    end

    // Slot storage; contents beyond count are don't-care, so no reset.
    always_ff @(posedge clk) begin
        q_bank  <= n_bank;
        q_row   <= n_row;
        q_col   <= n_col;
        q_write <= n_write;
        q_tag   <= n_tag;
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_push_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> count < CNT_W'(DEPTH));
endmodule

// File: rtl/hbp_match.sv
// Partner search: finds the oldest slot after slot 0 with the same bank,
// row and direction as slot 0. Assumes slots below count are valid.
// No search is made in compatibility mode.
module hbp_match #(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 4,
    parameter int ROW_W  = 14,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              compat,
    input  logic [CNT_W-1:0]  count,
    input  logic [BANK_W-1:0] q_bank  [DEPTH],
    input  logic [ROW_W-1:0]  q_row   [DEPTH],
    input  logic              q_write [DEPTH],
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    // Descending scan so the lowest (oldest) matching slot wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = DEPTH - 1; k >= 1; k--) begin
            if (!compat && k < int'(count) && q_bank[k] == q_bank[0] &&
                q_row[k] == q_row[0] && q_write[k] == q_write[0]) begin
                found = 1'b1;
                idx   = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/hbp_cmd_fmt.sv
// Command formatter: picks paired, half-width or full-width form from the
// search result and configuration, and sets the burst length and byte count.
// Assumes the partner inputs are meaningful only when found is set.
module hbp_cmd_fmt
    import hbp_pkg::*;
#(
    parameter int COL_W = 7,
    parameter int TAG_W = 4
) (
    input  logic               cfg_qdr,
    input  logic               cfg_compat,
    input  logic               cfg_lone_full,
    input  logic               found,
    input  logic [COL_W-1:0]   lo_col,
    input  logic [TAG_W-1:0]   lo_tag,
    input  logic [COL_W-1:0]   p_col,
    input  logic [TAG_W-1:0]   p_tag,
    output logic [COL_W-1:0]   hi_col,
    output logic [TAG_W-1:0]   hi_tag,
    output logic               hi_valid,
    output logic               full,
    output logic [BURST_W-1:0] burst,
    output logic [BYTES_W-1:0] bytes
);
    hbp_kind_e kind;

    // Command form: compatibility forces full width, else pair or lone policy.
    always_comb begin
        if (cfg_compat)         kind = KIND_FULL;
        else if (found)         kind = KIND_PAIR;
        else if (cfg_lone_full) kind = KIND_FULL;
        else                    kind = KIND_HALF;
    end

    // Field decode from the chosen form.
    always_comb begin
        hi_valid = (kind == KIND_PAIR);
        full     = (kind == KIND_FULL);
        hi_col   = hi_valid ? p_col : lo_col;
        hi_tag   = hi_valid ? p_tag : lo_tag;
        burst    = cfg_qdr ? BURST_W'(QDR_BURST) : BURST_W'(DDR_BURST);
        bytes    = BYTES_W'(int'(burst) * HALF_BYTES * ((kind == KIND_HALF) ? 1 : 2));
    end
endmodule

// File: rtl/halfbus_pairer.sv
// Top of the same-page half-bus pairer. It serves the oldest request on the
// lower half and puts its oldest same-page, same-direction partner on the
// upper half. It removes both requests when the command is accepted.
// Assumes the page is already open; no timing or data path is handled here.
module halfbus_pairer
    import hbp_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 4,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 7,
    parameter int TAG_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_qdr,
    input  logic               cfg_compat,
    input  logic               cfg_lone_full,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [BANK_W-1:0]  req_bank,
    input  logic [ROW_W-1:0]   req_row,
    input  logic [COL_W-1:0]   req_col,
    input  logic               req_write,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [BANK_W-1:0]  cmd_bank,
    output logic [ROW_W-1:0]   cmd_row,
    output logic               cmd_write,
    output logic [COL_W-1:0]   cmd_lo_col,
    output logic [TAG_W-1:0]   cmd_lo_tag,
    output logic               cmd_hi_valid,
    output logic [COL_W-1:0]   cmd_hi_col,
    output logic [TAG_W-1:0]   cmd_hi_tag,
    output logic               cmd_full,
    output logic [BURST_W-1:0] cmd_burst,
    output logic [BYTES_W-1:0] cmd_bytes
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [CNT_W-1:0]  count;
    logic [BANK_W-1:0] q_bank  [DEPTH];
    logic [ROW_W-1:0]  q_row   [DEPTH];
    logic [COL_W-1:0]  q_col   [DEPTH];
    logic              q_write [DEPTH];
    logic [TAG_W-1:0]  q_tag   [DEPTH];
    logic              found;
    logic [IDX_W-1:0]  p_idx;
    logic              push;
    logic              fire;

    // Handshake terms at both edges of the block.
    always_comb begin
        req_ready = (count < CNT_W'(DEPTH));
        push      = req_valid && req_ready;
        cmd_valid = (count != '0);
        fire      = cmd_valid && cmd_ready;
    end

    hbp_queue #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_bank(req_bank), .push_row(req_row), .push_col(req_col), .push_write(req_write),
        .pop(fire), .pop_two(cmd_hi_valid), .pop_idx(p_idx),
        .count(count), .q_bank(q_bank), .q_row(q_row), .q_col(q_col), .q_write(q_write), .q_tag(q_tag)
    );

    hbp_match #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_match (
        .compat(cfg_compat), .count(count),
        .q_bank(q_bank), .q_row(q_row), .q_write(q_write),
        .found(found), .idx(p_idx)
    );

    hbp_cmd_fmt #(.COL_W(COL_W), .TAG_W(TAG_W)) u_fmt (
        .cfg_qdr(cfg_qdr), .cfg_compat(cfg_compat), .cfg_lone_full(cfg_lone_full),
        .found(found), .lo_col(q_col[0]), .lo_tag(q_tag[0]),
        .p_col(q_col[p_idx]), .p_tag(q_tag[p_idx]),
        .hi_col(cmd_hi_col), .hi_tag(cmd_hi_tag), .hi_valid(cmd_hi_valid),
        .full(cmd_full), .burst(cmd_burst), .bytes(cmd_bytes)
    );

    // Lower-half fields come straight from the oldest slot.
    always_comb begin
        cmd_bank   = q_bank[0];
        cmd_row    = q_row[0];
        cmd_write  = q_write[0];
        cmd_lo_col = q_col[0];
        cmd_lo_tag = q_tag[0];
    end

    assert_pair_removal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_hi_valid && !push |=> count + CNT_W'(2) == $past(count));
    assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && !push |=> count == $past(count));
    assert_compat_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cfg_compat |-> cmd_full && !cmd_hi_valid);
    assert_full_cols_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_full |-> cmd_hi_col == cmd_lo_col);
    assert_distinct_tags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_hi_valid |-> cmd_hi_tag != cmd_lo_tag);
endmodule

// File: tb/sim_halfbus_pairer.sv
// Bench: a queue-based behavioural model of the pairer, compared with the
// design on every clock.
module sim_halfbus_pairer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_qdr = 1'b1, cfg_compat = 1'b0, cfg_lone_full = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, cmd_ready = 1'b0;
    logic [3:0] req_bank = '0;
    logic [13:0] req_row = '0;
    logic [6:0] req_col = '0;
    logic req_ready, cmd_valid, cmd_write, cmd_hi_valid, cmd_full;
    logic [3:0] cmd_bank, cmd_lo_tag, cmd_hi_tag;
    logic [13:0] cmd_row;
    logic [6:0] cmd_lo_col, cmd_hi_col;
    logic [4:0] cmd_burst;
    logic [6:0] cmd_bytes;

    always #5 clk = ~clk;

    halfbus_pairer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_qdr(cfg_qdr), .cfg_compat(cfg_compat), .cfg_lone_full(cfg_lone_full),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_write(req_write), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_write(cmd_write), .cmd_lo_col(cmd_lo_col),
        .cmd_lo_tag(cmd_lo_tag), .cmd_hi_valid(cmd_hi_valid), .cmd_hi_col(cmd_hi_col),
        .cmd_hi_tag(cmd_hi_tag), .cmd_full(cmd_full), .cmd_burst(cmd_burst), .cmd_bytes(cmd_bytes)
    );

    int n_tests = 0, n_fail = 0, cyc = 0;
    int mb[$], mr[$], mc[$], mw[$], mt[$];
    int next_tag = 0;
    string ctx = "R3";
    bit [31:0] lf = 32'h1D2C_3B4A;

    task automatic chk(input string rq, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    function automatic bit [31:0] rnd();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        return lf;
    endfunction

    // One cycle: drive at negedge, compare outputs with the model, advance the model.
    task automatic step(input bit rv, input int b, input int r, input int c, input bit w, input bit cr);
        int sz, j, lbl_i, burst;
        bit mixed;
        string lbl;
        @(negedge clk);
        req_valid = rv; req_bank = 4'(b); req_row = 14'(r); req_col = 7'(c); req_write = w; cmd_ready = cr;
        #1;
        sz = mb.size();
        chk("R2", int'(req_ready), int'(sz < 8));
        chk(ctx, int'(cmd_valid), int'(sz > 0));
        j = -1;
        mixed = 1'b0;
        if (sz > 0) begin
            chk(ctx, int'(cmd_bank), mb[0]);
            chk(ctx, int'(cmd_row), mr[0]);
            chk(ctx, int'(cmd_write), mw[0]);
            chk(ctx, int'(cmd_lo_col), mc[0]);
            chk(ctx, int'(cmd_lo_tag), mt[0]);
            if (!cfg_compat)
                for (int k = 1; k < sz; k++)
                    if (mb[k] == mb[0] && mr[k] == mr[0]) begin
                        if (mw[k] == mw[0]) begin
                            if (j < 0) j = k;
                        end else mixed = 1'b1;
                    end
            if (cfg_compat) lbl = "R6";
            else if (j >= 0) lbl = "R4";
            else if (mixed) lbl = "R5";
            else if (cfg_lone_full) lbl = "R7";
            else lbl = "R8";
            chk(lbl, int'(cmd_hi_valid), int'(j >= 0));
            chk(lbl, int'(cmd_full), int'(cfg_compat || (j < 0 && cfg_lone_full)));
            chk(lbl, int'(cmd_hi_col), (j >= 0) ? mc[j] : mc[0]);
            chk(lbl, int'(cmd_hi_tag), (j >= 0) ? mt[j] : mt[0]);
            burst = cfg_qdr ? 16 : 8;
            chk("R9", int'(cmd_burst), burst);
            lbl_i = (j >= 0 || cfg_compat || cfg_lone_full) ? 4 : 2;
            chk("R10", int'(cmd_bytes), burst * lbl_i);
        end
        ctx = "R3";
        if (sz > 0 && cr) begin
            if (j >= 0) begin
                mb.delete(j); mr.delete(j); mc.delete(j); mw.delete(j); mt.delete(j);
                ctx = "R11";
            end
            mb.delete(0); mr.delete(0); mc.delete(0); mw.delete(0); mt.delete(0);
        end else if (sz > 0) ctx = "R12";
        if (rv && sz < 8) begin
            mb.push_back(b); mr.push_back(r); mc.push_back(c); mw.push_back(int'(w)); mt.push_back(next_tag);
            next_tag = (next_tag + 1) % 16;
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", int'(cmd_valid), 0);
        chk("R1", int'(req_ready), 1);
        rst_n = 1'b1;
        // Directed: stalled fill past capacity with mixed pages and directions.
        cfg_qdr = 1'b1; cfg_compat = 1'b0; cfg_lone_full = 1'b0;
        step(1, 0, 5, 10, 0, 0);
        step(1, 1, 5, 11, 0, 0);
        step(1, 0, 5, 12, 1, 0);
        step(1, 0, 5, 13, 0, 0);
        step(1, 0, 6, 14, 0, 0);
        step(1, 0, 5, 15, 0, 0);
        step(1, 0, 5, 16, 1, 0);
        step(1, 2, 2, 17, 1, 0);
        step(1, 0, 5, 18, 0, 0);
        step(1, 0, 5, 19, 0, 0);
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 1);
        // Randomised traffic over every configuration combination.
        for (int m = 0; m < 8; m++) begin
            cfg_qdr = m[0]; cfg_compat = m[1]; cfg_lone_full = m[2];
            for (int i = 0; i < 300; i++) begin
                bit [31:0] v;
                v = rnd();
                step(v[3:0] < 11, int'(v[4]), int'(v[5]), int'(v[12:6]), v[13], v[17:14] < 10);
            end
            for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 1);
        end
        finish_run();
    end
endmodule